// File: doc/BRIEF.md
# Registered Sequential Select Decoder

A free-running binary counter steps through its states and drives a one-of-N decoder. The decoder's select lines are active low and become active one at a time, in turn. A decoder built only from gates can give short false pulses when several counter bits change on the same edge, for example 3 to 4 or 7 to 0. To prevent this, every select line leaves the block through a flip-flop clocked by the counter clock. The register is loaded from a decode of the counter's *next* state. As a result, registered line k is low for exactly the cycle in which the counter holds k, with no lag of one cycle.

Three gating inputs qualify the decode: one active high and two active low. If any of them is not asserted at a clock edge, all lines are high for the following cycle. The counter keeps advancing while the lines are gated off, so when the gate opens again the active line shows the true count. A synchronous active-low reset returns the counter to 0 and makes line 0 active.

Top module: `seq_select_decoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, the counter is set to 0 and `sel_n` becomes 8'hFE after that edge (bit 0 low, all others high), whatever the gating inputs are.
- R2: When the gate is open at every edge, the low bit of `sel_n` moves from bit k to bit (k+1) mod 8 on each rising edge, so the order is 0,1,...,7,0. The first edge after reset is released moves it to bit 1.
- R3: After any edge at which the gate is open (`gate_hi`=1, `gate_a_n`=0, `gate_b_n`=0), exactly one bit of `sel_n` is low.
- R4: After any edge at which the gate is closed, `sel_n` is 8'hFF.
- R5: The counter advances on every edge outside reset whether the gate is open or closed. After the gate reopens, the low bit is the number of edges since reset release, mod 8.
- R6: Each of the three gating inputs closes the gate by itself: `gate_hi`=0 alone, `gate_a_n`=1 alone, or `gate_b_n`=1 alone drives `sel_n` to 8'hFF.
- R7: `sel_n` changes only at rising clock edges and never between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counter and the select register |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_hi | input | 1 | Decode gate, active high |
| gate_a_n | input | 1 | Decode gate, active low |
| gate_b_n | input | 1 | Decode gate, active low |
| sel_n | output | 8 | Registered select lines, active low |

## Verification
The checker tests on every cycle that reset loads 8'hFE, that an open gate leaves exactly one low line, that a closed gate forces all lines high, and that the low line rotates by one position under a continuously open gate. Only the bench scenarios can show that the count keeps advancing while the lines are gated off and reappears at the right position, and that each gating input closes the gate alone. The bench also watches `sel_n` for any change that falls outside a rising edge.

// File: rtl/seq_select_pkg.sv
// Shared sizing for the sequential select decoder.
// Assumes the counter width is small (the line count is 2**width).
package seq_select_pkg;
    localparam int unsigned CNT_W   = 3;
    localparam int unsigned N_LINES = 1 << CNT_W;
endpackage

// File: rtl/seq_step_counter.sv
// Free-running modulo-2**W binary counter with synchronous active-low reset.
// Also presents the state it will take at the next edge.
// Assumes the counter wraps naturally at 2**W.
module seq_step_counter #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count,
    output logic [W-1:0] count_next
);
    // Next state: increment with natural wrap, or zero under reset.
    always_comb begin
        count_next = rst_n ? count + 1'b1 : '0;
    end

    // State register.
    always_ff @(posedge clk) begin
        count <= count_next;
    end
endmodule

// File: rtl/seq_line_decoder.sv
// Combinational one-of-2**W decoder with active-low lines.
// All lines are high unless the gate is open.
// Assumes its output feeds a register, so hazards here are harmless.
module seq_line_decoder #(
    parameter int unsigned W = 3,
    localparam int unsigned N = 1 << W
) (
    input  logic [W-1:0] index,
    input  logic         gate_open,
    output logic [N-1:0] lines_n
);
    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_line
            localparam logic [W-1:0] K_IDX = k[W-1:0];
            // One comparator per line, gated.
            assign lines_n[k] = ~(gate_open && (index == K_IDX));
        end
    endgenerate
endmodule

// File: rtl/seq_select_reg.sv
// Output register for the select lines. Loads the decoded next state.
// Under reset it holds line 0 active to match counter state 0.
// Assumes a synchronous active-low reset.
module seq_select_reg #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_n,
    output logic [N-1:0] q_n
);
    localparam logic [N-1:0] RESET_LINES = ~{{(N-1){1'b0}}, 1'b1};

    // Capture the decoded lines, or line 0 active on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_n <= RESET_LINES;
        else        q_n <= d_n;
    end
endmodule

// File: rtl/seq_select_decoder.sv
// Counter-driven select decoder with registered, spike-free outputs.
// Decodes the counter's next state, so registered line k is low while
// the counter holds k. Assumes all inputs are synchronous to clk.
module seq_select_decoder
    import seq_select_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gate_hi,
    input  logic               gate_a_n,
    input  logic               gate_b_n,
    output logic [N_LINES-1:0] sel_n
);
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   count_next;
    logic [N_LINES-1:0] decoded_n;
    logic               gate_open;

    // Combine the three gating inputs.
    always_comb begin
        gate_open = gate_hi && !gate_a_n && !gate_b_n;
    end

    seq_step_counter #(.W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (count),
        .count_next (count_next)
    );

    seq_line_decoder #(.W(CNT_W)) u_decode (
        .index     (count_next),
        .gate_open (gate_open),
        .lines_n   (decoded_n)
    );

    seq_select_reg #(.N(N_LINES)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_n   (decoded_n),
        .q_n   (sel_n)
    );
endmodule

// File: rtl/seq_select_decoder_chk.sv
// Checker for the select decoder, observing its ports only.
module seq_select_decoder_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         gate_hi,
    input logic         gate_a_n,
    input logic         gate_b_n,
    input logic [N-1:0] sel_n
);
    logic open_now;
    assign open_now = gate_hi && !gate_a_n && !gate_b_n;

    // R1
    reset_lines_chk: assert property (@(posedge clk)
        !rst_n |=> sel_n == ~{{(N-1){1'b0}}, 1'b1});

    // R3
    one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_now |=> $countones(~sel_n) == 1);

    // R4
    gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_now |=> sel_n == '1);

    // R2
    rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_now && $countones(~sel_n) == 1) |=>
            sel_n == $past({sel_n[N-2:0], sel_n[N-1]}));
endmodule

bind seq_select_decoder seq_select_decoder_chk #(.N(seq_select_pkg::N_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_hi  (gate_hi),
    .gate_a_n (gate_a_n),
    .gate_b_n (gate_b_n),
    .sel_n    (sel_n)
);

// File: tb/seq_select_decoder_test.sv
`timescale 1ns/1ps
module seq_select_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate_hi = 1'b1;
    logic       gate_a_n = 1'b0;
    logic       gate_b_n = 1'b0;
    logic [7:0] sel_n;

    int checks = 0;
    int fails = 0;
    int model_cnt = 0;
    logic [7:0] model_sel = 8'hFE;
    bit   model_valid = 0;
    string tag = "R1";
    realtime last_edge = 0.0;
    int off_edge_changes = 0;

    seq_select_decoder uut (
        .clk(clk), .rst_n(rst_n), .gate_hi(gate_hi),
        .gate_a_n(gate_a_n), .gate_b_n(gate_b_n), .sel_n(sel_n)
    );

    always #2 clk = ~clk;

    // Behavioural reference, advanced on each rising edge.
    always @(posedge clk) begin
        last_edge = $realtime;
        if (!rst_n) begin
            model_cnt = 0;
            model_sel = 8'hFE;
            model_valid = 1;
        end else if (model_valid) begin
            model_cnt = (model_cnt + 1) % 8;
            if (gate_hi && !gate_a_n && !gate_b_n)
                model_sel = ~(8'd1 << model_cnt);
            else
                model_sel = 8'hFF;
        end
    end

    // R7: any output change must coincide with a rising edge.
    always @(sel_n) begin
        if ($realtime != last_edge && $realtime > 0.0) off_edge_changes++;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: sel_n=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare on every falling edge, well away from the active edge.
    always @(negedge clk) begin
        if (model_valid) begin
            check(tag, sel_n, model_sel);
            if (model_sel != 8'hFF) begin
                checks++;
                if ($countones(~sel_n) != 1) begin
                    fails++;
                    $display("FAIL R3: %0d low bits, expected 1", $countones(~sel_n));
                end
            end
        end
    end

    task automatic run(input int n, input bit h, input bit a, input bit b, input string t);
        @(negedge clk);
        #0.5;
        gate_hi = h; gate_a_n = a; gate_b_n = b; tag = t;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset, with the gate closed to show it does not matter
        gate_hi = 1'b0; tag = "R1";
        repeat (3) @(negedge clk);
        #0.5;
        rst_n = 1'b1; gate_hi = 1'b1; tag = "R2";
        repeat (20) @(negedge clk);          // R2 wrap several times
        run(3, 0, 0, 0, "R6");               // gate_hi alone
        run(2, 1, 0, 0, "R5");
        run(4, 1, 1, 0, "R6");               // gate_a_n alone
        run(3, 1, 0, 0, "R5");
        run(5, 1, 0, 1, "R6");               // gate_b_n alone
        run(3, 1, 0, 0, "R5");
        run(11, 0, 1, 1, "R4");
        run(9, 1, 0, 0, "R5");
        // R1 mid-run reset with gate open
        @(negedge clk); #0.5; rst_n = 1'b0; tag = "R1";
        repeat (2) @(negedge clk);
        #0.5; rst_n = 1'b1; tag = "R2";
        repeat (10) @(negedge clk);
        checks++;
        if (off_edge_changes != 0) begin
            fails++;
            $display("FAIL R7: %0d off-edge changes, expected 0", off_edge_changes);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule